// File: doc/BRIEF.md
# PCI Target User-Side Address and Command Decoder

This block sits between the simplified back-end port of a PCI target core and a small bank of 32-bit user registers. The core announces each new transaction with a single-cycle address-valid pulse. In that cycle the address and the bus command are both present, and the block decodes them at once. It reports whether the command is a user read or a user write. It also reports whether the address hits its base-address window while the matching space enable is on.

The core never presents the address again, so the block keeps its own burst pointer. It loads the pointer from the announced address and advances it by one dword per completed beat. An increment strobe has two meanings. In a write transaction it marks a beat of valid data, and the block takes that beat unconditionally. In a read transaction it only says the core can take data. A read beat completes only when the block's own ready output is also high.

The block models a registered back-end. After each change of the read pointer it holds ready low for one cycle while the read data register catches up with the new address.

Top module: `pci_user_decoder`

## Requirements
- R1: While `addr_valid` is high, `rd_decode` is high exactly when `cbe_n` holds one of the read codes 4'b0010 (I/O read), 4'b0110 (memory read), 4'b1100 (memory read multiple) or 4'b1110 (memory read line). It is low whenever `addr_valid` is low.
- R2: While `addr_valid` is high, `wr_decode` is high exactly when `cbe_n` holds one of the write codes 4'b0011 (I/O write), 4'b0111 (memory write) or 4'b1111 (memory write and invalidate). It is low whenever `addr_valid` is low.
- R3: `select` is high only while `addr_valid` is high, the command is a read or write code from R1/R2, and `ad_in[31:WIN_AW]` equals `bar_base[31:WIN_AW]`. In addition, `io_space_en` must be high for the I/O codes (4'b001x) and `mem_space_en` must be high for all other codes.
- R4: In the cycle after `addr_valid`, `cur_addr` equals the announced address with bits [1:0] cleared. This load happens whether or not the transaction hits.
- R5: In a write transaction that hit, every `addr_inc` cycle advances `cur_addr` by 4, whatever the state of `rdy`. Such a cycle raises `wr_strobe` if `cur_addr` lies inside the window. A beat whose pointer has run past the window end writes nothing.
- R6: On a write beat, byte lane k of the addressed register takes `ad_in[8k+7:8k]` only when `cbe_n[k]` is 0 (active-low enables). The other lanes keep their contents.
- R7: In a read transaction that hit, `cur_addr` advances by 4 only in cycles where `addr_inc` and `rdy` are both high.
- R8: `rdy` is low in the cycle that follows the load of a read pointer and in the cycle that follows each completed read beat. Otherwise it is high for as long as the last announced transaction was a read that hit. It is low at all other times.
- R9: Whenever `rdy` is high, `rd_data` holds the register addressed by `cur_addr[WIN_AW-1:2]`. If `cur_addr` lies outside the window, `rd_data` is zero.
- R10: After reset, all outputs are zero and every register in the bank reads as zero.
- R11: A transaction that does not hit leaves the bank and `cur_addr` untouched by its `addr_inc` cycles, and it keeps `rdy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Back-end clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | One-cycle marker of a new transaction |
| ad_in | input | 32 | Address while `addr_valid`, write data on write beats |
| cbe_n | input | 4 | Command while `addr_valid`, active-low byte enables otherwise |
| addr_inc | input | 1 | Beat strobe from the core |
| bar_base | input | 32 | Window base address; bits below WIN_AW ignored |
| mem_space_en | input | 1 | Memory space enable |
| io_space_en | input | 1 | I/O space enable |
| rd_decode | output | 1 | User read command decoded |
| wr_decode | output | 1 | User write command decoded |
| select | output | 1 | Address hit, gated by the space enable |
| rdy | output | 1 | Back-end ready for a read beat |
| rd_data | output | 32 | Read data toward the core |
| wr_strobe | output | 1 | Write enable into the register bank |
| cur_addr | output | 32 | Burst address pointer |

## Verification
A pointer that loads wrongly or steps at the wrong moment shows on `cur_addr` one cycle later. Within two cycles it also shows as read data from the wrong register. A lost or extra write beat stays hidden until a later read of that register, so every write burst is followed by reads over the same range. A stuck change flag or transaction-active flag shows at once on `rdy`, in the first data cycle of the next read.

// File: rtl/pud_pkg.sv
package pud_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned BYTES = DW / 8;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  function automatic logic is_rd_cmd(input logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_MEM_RD) ||
           (c == CMD_MEM_RDM) || (c == CMD_MEM_RDL);
  endfunction

  function automatic logic is_wr_cmd(input logic [3:0] c);
    return (c == CMD_IO_WR) || (c == CMD_MEM_WR) || (c == CMD_MEM_WRI);
  endfunction

  function automatic logic is_io_cmd(input logic [3:0] c);
    return c[3:1] == 3'b001;
  endfunction

  // Window check: the upper address bits match the base.
  function automatic logic in_window(input logic [DW-1:0] a,
                                     input logic [DW-1:0] base,
                                     input int unsigned    win_aw);
    logic [DW-1:0] mask;
    mask = ~((DW'(1) << win_aw) - DW'(1));
    return (a & mask) == (base & mask);
  endfunction

  function automatic logic [DW-1:0] step_addr(input logic [DW-1:0] a);
    return a + DW'(4);
  endfunction

  function automatic logic [DW-1:0] align_addr(input logic [DW-1:0] a);
    return {a[DW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/pud_cmd_decode.sv
module pud_cmd_decode
  import pud_pkg::*;
#(
  parameter int unsigned WIN_AW = 6
) (
  input  logic          addr_valid,
  input  logic [DW-1:0] addr,
  input  logic [3:0]    cmd,
  input  logic [DW-1:0] bar_base,
  input  logic          mem_en,
  input  logic          io_en,
  output logic          rd_dec,
  output logic          wr_dec,
  output logic          sel
);
  logic space_ok;
  logic hit_win;

  always_comb begin
    rd_dec   = addr_valid & is_rd_cmd(cmd);
    wr_dec   = addr_valid & is_wr_cmd(cmd);
    space_ok = is_io_cmd(cmd) ? io_en : mem_en;
    hit_win  = in_window(addr, bar_base, WIN_AW);
    sel      = (rd_dec | wr_dec) & hit_win & space_ok;
  end
endmodule

// File: rtl/pud_burst_ctr.sv
module pud_burst_ctr
  import pud_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_addr,
  input  logic          step,
  output logic [DW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (load)   addr_q <= align_addr(load_addr);
    else if (step)   addr_q <= step_addr(addr_q);
  end
endmodule

// File: rtl/pud_reg_bank.sv
module pud_reg_bank
  import pud_pkg::*;
#(
  parameter int unsigned WIN_AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  input  logic [BYTES-1:0] be_n,
  input  logic             rd_ok,
  input  logic [DW-1:0]    addr,
  output logic [DW-1:0]    rdata
);
  localparam int unsigned IW    = WIN_AW - 2;
  localparam int unsigned DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;

  assign idx = addr[WIN_AW-1:2];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[w][8*b +: 8] <= '0;
        else if (we && !be_n[b] && (idx == IW'(w)))
          mem[w][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_ok) rdata <= mem[idx];
    else            rdata <= '0;
  end
endmodule

// File: rtl/pci_user_decoder.sv
module pci_user_decoder
  import pud_pkg::*;
#(
  parameter int unsigned WIN_AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_valid,
  input  logic [31:0]   ad_in,
  input  logic [3:0]    cbe_n,
  input  logic          addr_inc,
  input  logic [31:0]   bar_base,
  input  logic          mem_space_en,
  input  logic          io_space_en,
  output logic          rd_decode,
  output logic          wr_decode,
  output logic          select,
  output logic          rdy,
  output logic [31:0]   rd_data,
  output logic          wr_strobe,
  output logic [31:0]   cur_addr
);
  // Named internal events, visible to the bound checker.
  logic rd_act, wr_act, addr_chg;
  logic rd_xfer, wr_beat, ptr_step, ptr_in_win;

  pud_cmd_decode #(.WIN_AW(WIN_AW)) u_dec (
    .addr_valid (addr_valid),
    .addr       (ad_in),
    .cmd        (cbe_n),
    .bar_base   (bar_base),
    .mem_en     (mem_space_en),
    .io_en      (io_space_en),
    .rd_dec     (rd_decode),
    .wr_dec     (wr_decode),
    .sel        (select)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act   <= 1'b0;
      wr_act   <= 1'b0;
      addr_chg <= 1'b0;
    end else begin
      if (addr_valid) begin
        rd_act <= rd_decode & select;
        wr_act <= wr_decode & select;
      end
      addr_chg <= (addr_valid & rd_decode & select) | rd_xfer;
    end
  end

  always_comb begin
    rdy        = rd_act & ~addr_chg;
    ptr_in_win = in_window(cur_addr, bar_base, WIN_AW);
    rd_xfer    = rd_act & addr_inc & rdy & ~addr_valid;
    wr_beat    = wr_act & addr_inc & ~addr_valid;
    wr_strobe  = wr_beat & ptr_in_win;
    ptr_step   = wr_beat | rd_xfer;
  end

  pud_burst_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_valid),
    .load_addr (ad_in),
    .step      (ptr_step),
    .addr_q    (cur_addr)
  );

  pud_reg_bank #(.WIN_AW(WIN_AW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_strobe),
    .wdata (ad_in),
    .be_n  (cbe_n),
    .rd_ok (ptr_in_win),
    .addr  (cur_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pud_chk.sv
module pud_chk #(
  parameter int unsigned WIN_AW = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_valid,
  input logic [31:0] ad_in,
  input logic        addr_inc,
  input logic        rd_decode,
  input logic        wr_decode,
  input logic        select,
  input logic        rdy,
  input logic        wr_strobe,
  input logic [31:0] cur_addr
);
  // R1
  rd_only_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_decode |-> addr_valid);
  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_decode && wr_decode));
  // R3
  sel_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    select |-> (rd_decode || wr_decode));
  // R4
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> cur_addr == {$past(ad_in[31:2]), 2'b00});
  // R5
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> cur_addr == $past(cur_addr) + 32'd4);
  // R7
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc && rdy && !addr_valid) |=> cur_addr == $past(cur_addr) + 32'd4);
  // R8
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc && rdy && !addr_valid) |=> !rdy);
  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !addr_inc) |=> $stable(cur_addr));
endmodule

bind pci_user_decoder pud_chk #(.WIN_AW(WIN_AW)) chk_i (.*);

// File: tb/pci_user_decoder_tb_top.sv
module pci_user_decoder_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WIN = 6;
  localparam int unsigned NW = 1 << (WIN - 2);
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int unsigned WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_valid = 1'b0, addr_inc = 1'b0;
  logic [31:0] ad_in = '0, bar_base = BASE;
  logic [3:0] cbe_n = '0;
  logic mem_space_en = 1'b1, io_space_en = 1'b1;
  logic rd_decode, wr_decode, select, rdy, wr_strobe;
  logic [31:0] rd_data, cur_addr;

  int n_tests = 0, n_fail = 0;
  logic [31:0] mdl [NW];
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_user_decoder #(.WIN_AW(WIN)) dut_i (.*);

  function automatic bit bf_read(input logic [3:0] c);
    case (c) 4'h2, 4'h6, 4'hC, 4'hE: return 1'b1; default: return 1'b0; endcase
  endfunction
  function automatic bit bf_write(input logic [3:0] c);
    case (c) 4'h3, 4'h7, 4'hF: return 1'b1; default: return 1'b0; endcase
  endfunction
  function automatic bit bf_inwin(input logic [31:0] a);
    return (a >> WIN) == (BASE >> WIN);
  endfunction
  function automatic bit bf_hit(input logic [31:0] a, input logic [3:0] c,
                                input bit me, input bit ie);
    bit en;
    en = (c == 4'h2 || c == 4'h3) ? ie : me;
    return (bf_read(c) || bf_write(c)) && bf_inwin(a) && en;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Announce a transaction; returns whether it hits.
  task automatic announce(input logic [31:0] a, input logic [3:0] c,
                          input bit me, input bit ie, output bit hit);
    @(negedge clk);
    mem_space_en = me; io_space_en = ie;
    addr_valid = 1'b1; ad_in = a; cbe_n = c; addr_inc = 1'b0;
    hit = bf_hit(a, c, me, ie);
    #1;
    check("R1 rd_decode", 32'(rd_decode), 32'(bf_read(c)));
    check("R2 wr_decode", 32'(wr_decode), 32'(bf_write(c)));
    check("R3 select", 32'(select), 32'(hit));
    @(negedge clk);
    addr_valid = 1'b0;
    #1;
    check("R4 pointer load", cur_addr, {a[31:2], 2'b00});
  endtask

  task automatic do_write(input logic [31:0] a, input logic [3:0] c,
                          input bit me, input bit ie, input int beats);
    bit hit;
    logic [31:0] p, d;
    logic [3:0] be;
    announce(a, c, me, ie, hit);
    p = {a[31:2], 2'b00};
    for (int i = 0; i < beats; i++) begin
      d = $urandom; be = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      ad_in = d; cbe_n = be; addr_inc = 1'b1;
      #1;
      check("R5 wr_strobe", 32'(wr_strobe), 32'(hit && bf_inwin(p)));
      check("R8 rdy low in write", 32'(rdy), 32'd0);
      if (hit && bf_inwin(p))
        for (int k = 0; k < 4; k++)
          if (!be[k]) mdl[p[WIN-1:2]][8*k +: 8] = d[8*k +: 8];
      if (hit) p = p + 4;
      @(negedge clk);
      addr_inc = 1'b0; cbe_n = 4'h0;
      #1;
      check(hit ? "R5 write step" : "R11 pointer held", cur_addr, p);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [3:0] c,
                         input bit me, input bit ie, input int beats);
    bit hit, chg, inc;
    int got;
    logic [31:0] p, exp_d;
    announce(a, c, me, ie, hit);
    p = {a[31:2], 2'b00}; chg = hit; got = 0;
    for (int cyc = 0; cyc < 4 * beats + 4 && got < beats; cyc++) begin
      inc = ($urandom % 4) != 0;
      addr_inc = inc;
      #1;
      check("R8 rdy", 32'(rdy), 32'(hit && !chg));
      if (hit && !chg) begin
        exp_d = bf_inwin(p) ? mdl[p[WIN-1:2]] : 32'h0;
        check("R9 rd_data", rd_data, exp_d);
      end
      if (hit && !chg && inc) begin p = p + 4; chg = 1'b1; got++; end
      else chg = 1'b0;
      @(negedge clk);
      addr_inc = 1'b0;
      #1;
      check(hit ? "R7 read step" : "R11 pointer held", cur_addr, p);
    end
  endtask

  initial begin : wd
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) disable wd;
    end
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit unused_hit;
    logic [3:0] cmds [10];
    logic [3:0] c;
    void'($urandom(32'd20250611));
    cmds = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hC, 4'hE, 4'hF, 4'h1, 4'hA, 4'h7};
    for (int i = 0; i < NW; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    check("R10 rdy", 32'(rdy), 0);
    check("R10 rd_data", rd_data, 0);
    check("R10 cur_addr", cur_addr, 0);
    check("R10 wr_strobe", 32'(wr_strobe), 0);
    check("R10 decodes", {29'd0, rd_decode, wr_decode, select}, 0);
    rst_n = 1'b1;
    // R10 bank cleared: read the whole window
    do_read(BASE, 4'h6, 1, 1, NW);
    // R5 R6 full burst write then read back
    do_write(BASE, 4'h7, 1, 1, NW);
    do_read(BASE, 4'hC, 1, 1, NW);
    // R5 burst running past window end, read across end (R9)
    do_write(BASE + 32'h38, 4'hF, 1, 1, 4);
    do_read(BASE + 32'h38, 4'hE, 1, 1, 4);
    // R3 space enables gate select; R11 no effect
    do_write(BASE + 32'h10, 4'h7, 0, 1, 3);
    do_write(BASE + 32'h10, 4'h3, 1, 0, 3);
    do_read(BASE + 32'h10, 4'h2, 1, 0, 2);
    do_write(BASE + 32'h10, 4'h3, 0, 1, 2);
    // R3 outside window, unsupported command, unaligned address (R4)
    do_write(BASE + 32'h40, 4'h7, 1, 1, 2);
    do_write(BASE + 32'h4, 4'h1, 1, 1, 2);
    do_read(BASE + 32'h7, 4'h6, 1, 1, 3);
    // Random mix
    for (int t = 0; t < 80; t++) begin
      logic [31:0] a;
      c = cmds[$urandom % 10];
      a = BASE - 32'd16 + 32'($urandom % 96);
      if (bf_read(c))
        do_read(a, c, ($urandom % 4) != 0, ($urandom % 4) != 0, 1 + $urandom % 6);
      else
        do_write(a, c, ($urandom % 4) != 0, ($urandom % 4) != 0, 1 + $urandom % 6);
    end
    do_read(BASE, 4'h6, 1, 1, NW);
    announce(BASE, 4'h0, 1, 1, unused_hit);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule